// File: doc/BRIEF.md
# Register-Run Transfer Sequencer

This block moves a run of general registers to or from memory, one access at a time. A single start strobe launches one of six operations: a word-wise load or store that covers every register from a chosen first register up to the last one, or a byte-wise string load or store. The byte count of a string transfer comes either from a small immediate field or from the low byte of a string-control value held elsewhere. The block computes the effective address and the length, and checks the operation for an alignment exception. It then walks the registers through a write port and a read port of the register file. Each step issues one memory request and waits for its acknowledge.

String bytes are packed big-endian. The first byte of a register sits in bits 31:24 and the fourth in bits 7:0. After the fourth byte the walk moves to the next register number, and the number wraps from the last register back to register 0. On a string load each destination register starts from zero. The register file is written after every byte with the value gathered so far, so a register that gets only part of its bytes ends with zero low bytes. An access fault ends the run at once. Registers and memory already updated keep their new contents.

Top module: `regrun_xfer`

## Requirements
- R1: Operation code 0 loads words into registers start_reg up to 31 in ascending order. The first word comes from the effective address, taken as (base_zero ? 0 : base_val) plus the sign-extended disp, and the address rises by 4 per register. A word is big-endian: the byte at address a lands in bits 31:24.
- R2: Operation code 1 stores registers start_reg up to 31 as words at the same addresses as R1 (mem_we=1, mem_size=1).
- R3: For codes 0 and 1, a nonzero effective address modulo 4, or le_mode=1, ends the operation with status 1 (alignment). No memory request is made and no register is written.
- R4: For the string codes 2 to 5, le_mode=1 ends the operation with status 1 and makes no memory request.
- R5: The immediate string codes (2 load, 3 store) start at address (base_zero ? 0 : base_val) and ignore disp. They transfer imm_nb bytes, and imm_nb=0 means 32 bytes.
- R6: The indexed string codes (4 load, 5 store) start at (base_zero ? 0 : base_val) + index_val and transfer str_cnt bytes. With str_cnt=0 the operation ends with status 0, no request and no register write.
- R7: String bytes use consecutive byte addresses (mem_size=0, data in bits 7:0). They fill bit offsets 24, 16, 8 and 0 of a register, then move to the next register number, which wraps from 31 to 0.
- R8: A string load clears each destination register before merging its first byte. A partially filled last register keeps zeros in the bytes not received, and registers beyond the count are untouched.
- R9: A string store sends the register bytes in the order bits 31:24, 23:16, 15:8, 7:0 and writes no byte beyond the count.
- R10: An acknowledge with mem_fault=1 ends the run with status 2. It makes no register write for that step and no further request. Earlier register and memory updates remain.
- R11: busy rises in the cycle after an accepted start and falls after the one-cycle done pulse. A start seen while busy is ignored. At most one request is outstanding, and mem_req, mem_addr and mem_we hold steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken when idle |
| op | input | 3 | Operation code 0..5 |
| start_reg | input | RIDX_W | First register of the run |
| base_zero | input | 1 | Use zero in place of base_val |
| base_val | input | AW | Base register contents |
| disp | input | 16 | Signed displacement for word transfers |
| index_val | input | AW | Index register contents for indexed strings |
| imm_nb | input | NB_W | Immediate byte count, 0 meaning 32 |
| str_cnt | input | CNT_W | Byte count for indexed strings |
| le_mode | input | 1 | Little-endian mode flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 alignment, 2 fault; valid with done |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 1 | 1 word, 0 byte |
| mem_addr | output | AW | Request address |
| mem_wdata | output | 32 | Write data (byte in bits 7:0) |
| mem_ack | input | 1 | Request completes this cycle |
| mem_fault | input | 1 | Completing access faulted |
| mem_rdata | input | 32 | Read data (byte in bits 7:0) |
| rf_we | output | 1 | Register write strobe |
| rf_waddr | output | RIDX_W | Register write index |
| rf_wdata | output | 32 | Register write data |
| rf_raddr | output | RIDX_W | Register read index |
| rf_rdata | input | 32 | Register read data |

## Verification
The bench aims at the wrap from register 31 to 0 with a 32-byte immediate count. A design that stops at 31 or forgets to clear would leave register 0 and the ones after it holding stale data. A destination preset to all ones then receives a single byte: a missing clear shows up as ones in its low bytes, and a lane shift in the wrong direction puts the byte in bits 7:0. A fault injected in the middle of a run must leave exactly the bytes before it in place. A design that wrote on the faulting step or kept requesting would disturb the next register. Misaligned and little-endian starts, together with a zero indexed count, must produce no request at all. A start pulsed during a run, with a store code, must not cause any memory write.

// File: rtl/regrun_pkg.sv
package regrun_pkg;
  typedef enum logic [2:0] {
    OP_LDM     = 3'd0,
    OP_STM     = 3'd1,
    OP_LDS_IMM = 3'd2,
    OP_STS_IMM = 3'd3,
    OP_LDS_IDX = 3'd4,
    OP_STS_IDX = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ALIGN = 2'd1,
    ST_FAULT = 2'd2
  } stat_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_XFER = 2'd1,
    S_FIN  = 2'd2
  } fsm_e;
endpackage

// File: rtl/regrun_setup.sv
module regrun_setup
  import regrun_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RIDX_W = 5,
  parameter int NB_W   = 5,
  parameter int CNT_W  = 8
) (
  input  logic [2:0]        op,
  input  logic [RIDX_W-1:0] start_reg,
  input  logic              base_zero,
  input  logic [AW-1:0]     base_val,
  input  logic [15:0]       disp,
  input  logic [AW-1:0]     index_val,
  input  logic [NB_W-1:0]   imm_nb,
  input  logic [CNT_W-1:0]  str_cnt,
  input  logic              le_mode,
  output logic [AW-1:0]     ea,
  output logic [CNT_W-1:0]  steps,
  output logic              align_err,
  output logic              empty
);
  localparam int NREG    = 1 << RIDX_W;
  localparam int NB_FULL = 1 << NB_W;

  logic [AW-1:0] base;
  logic [AW-1:0] dext;
  logic          is_word;
  logic          is_imm;

  always_comb begin
    base    = base_zero ? '0 : base_val;
    dext    = {{(AW-16){disp[15]}}, disp};
    is_word = (op == OP_LDM) || (op == OP_STM);
    is_imm  = (op == OP_LDS_IMM) || (op == OP_STS_IMM);
    if (is_word) begin
      ea        = base + dext;
      steps     = CNT_W'(NREG) - CNT_W'(start_reg);
      align_err = le_mode || (ea[1:0] != 2'b00);
    end else if (is_imm) begin
      ea        = base;
      steps     = (imm_nb == '0) ? CNT_W'(NB_FULL) : CNT_W'(imm_nb);
      align_err = le_mode;
    end else begin
      ea        = base + index_val;
      steps     = str_cnt;
      align_err = le_mode;
    end
    empty = (steps == '0);
  end
endmodule

// File: rtl/regrun_lane.sv
module regrun_lane (
  input  logic [1:0]  lane,
  input  logic [31:0] acc,
  input  logic [7:0]  byte_in,
  input  logic [31:0] word_in,
  output logic [31:0] merged,
  output logic [7:0]  byte_out
);
  localparam int LANES = 4;

  logic [7:0] pick [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_pick
    assign pick[g] = word_in[31-8*g -: 8];
  end

  logic [4:0]  shamt;
  logic [31:0] keep;

  always_comb begin
    shamt    = {~lane, 3'b000};
    keep     = (lane == 2'd0) ? 32'h0 : acc;
    merged   = keep | ({24'h0, byte_in} << shamt);
    byte_out = pick[lane];
  end
endmodule

// File: rtl/regrun_xfer.sv
module regrun_xfer
  import regrun_pkg::*;
#(
  parameter int AW     = 32,
  parameter int RIDX_W = 5,
  parameter int NB_W   = 5,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [RIDX_W-1:0] start_reg,
  input  logic              base_zero,
  input  logic [AW-1:0]     base_val,
  input  logic [15:0]       disp,
  input  logic [AW-1:0]     index_val,
  input  logic [NB_W-1:0]   imm_nb,
  input  logic [CNT_W-1:0]  str_cnt,
  input  logic              le_mode,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_size,
  output logic [AW-1:0]     mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_fault,
  input  logic [31:0]       mem_rdata,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_waddr,
  output logic [31:0]       rf_wdata,
  output logic [RIDX_W-1:0] rf_raddr,
  input  logic [31:0]       rf_rdata
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic [AW-1:0]    ea;
  logic [CNT_W-1:0] steps;
  logic             align_err, empty;

  regrun_setup #(.AW(AW), .RIDX_W(RIDX_W), .NB_W(NB_W), .CNT_W(CNT_W)) u_setup (
    .op(op), .start_reg(start_reg), .base_zero(base_zero), .base_val(base_val),
    .disp(disp), .index_val(index_val), .imm_nb(imm_nb), .str_cnt(str_cnt),
    .le_mode(le_mode), .ea(ea), .steps(steps), .align_err(align_err), .empty(empty)
  );

  fsm_e              state_q, state_d;
  logic [AW-1:0]     addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [RIDX_W-1:0] ptr_q, ptr_d;
  logic [1:0]        lane_q, lane_d;
  logic [31:0]       acc_q, acc_d;
  logic              load_q, load_d;
  logic              str_q, str_d;
  logic [1:0]        stat_q, stat_d;

  logic [31:0] merged;
  logic [7:0]  byte_out;

  regrun_lane u_lane (
    .lane(lane_q), .acc(acc_q), .byte_in(mem_rdata[7:0]), .word_in(rf_rdata),
    .merged(merged), .byte_out(byte_out)
  );

  logic accept, step_ok, step_en;

  always_comb begin
    accept   = (state_q == S_IDLE) && start;
    step_ok  = (state_q == S_XFER) && mem_ack && !mem_fault;
    step_en  = accept || step_ok;
    state_d  = state_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    ptr_d    = ptr_q;
    lane_d   = lane_q;
    acc_d    = acc_q;
    load_d   = load_q;
    str_d    = str_q;
    stat_d   = stat_q;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          load_d   = ~op[0];
          str_d    = (op != OP_LDM) && (op != OP_STM);
          addr_d   = ea;
          remain_d = steps;
          ptr_d    = start_reg;
          lane_d   = 2'd0;
          acc_d    = 32'h0;
          stat_d   = align_err ? ST_ALIGN : ST_OK;
          state_d  = (align_err || empty) ? S_FIN : S_XFER;
        end
      end
      S_XFER: begin
        if (mem_ack && mem_fault) begin
          stat_d  = ST_FAULT;
          state_d = S_FIN;
        end else if (mem_ack) begin
          remain_d = remain_q - CNT_W'(1);
          if (str_q) begin
            addr_d = addr_q + AW'(1);
            lane_d = lane_q + 2'd1;
            acc_d  = merged;
            if (lane_q == 2'd3) ptr_d = ptr_q + RIDX_W'(1);
          end else begin
            addr_d = addr_q + AW'(4);
            ptr_d  = ptr_q + RIDX_W'(1);
          end
          if (remain_q == CNT_W'(1)) state_d = S_FIN;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      remain_q <= '0;
      ptr_q    <= '0;
      lane_q   <= 2'd0;
      acc_q    <= 32'h0;
      load_q   <= 1'b0;
      str_q    <= 1'b0;
      stat_q   <= ST_OK;
    end else begin
      state_q <= state_d;
      if (step_en) begin
        addr_q   <= addr_d;
        remain_q <= remain_d;
        ptr_q    <= ptr_d;
        lane_q   <= lane_d;
        acc_q    <= acc_d;
      end
      if (accept) begin
        load_q <= load_d;
        str_q  <= str_d;
      end
      if (accept || (state_q == S_XFER && mem_ack)) stat_q <= stat_d;
    end
  end

  always_comb begin
    busy      = (state_q != S_IDLE);
    done      = (state_q == S_FIN);
    status    = stat_q;
    mem_req   = (state_q == S_XFER);
    mem_we    = ~load_q;
    mem_size  = ~str_q;
    mem_addr  = addr_q;
    mem_wdata = str_q ? {24'h0, byte_out} : rf_rdata;
    rf_raddr  = ptr_q;
    rf_waddr  = ptr_q;
    rf_we     = step_ok && load_q;
    rf_wdata  = str_q ? merged : mem_rdata;
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R3
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && mem_size) |-> (mem_addr[1:0] == 2'b00));
  // R10
  fault_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_ack && mem_fault) |-> !rf_we);
  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_req && mem_ack && mem_fault) |=> !mem_req);
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rf_we && str_q && lane_q == 2'd0) |-> (rf_wdata[23:0] == 24'h0));
  // R11
  done_chk: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !busy);
endmodule

// File: tb/test_regrun_xfer.sv
module test_regrun_xfer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [2:0]  op;
  logic [4:0]  start_reg;
  logic        base_zero;
  logic [31:0] base_val;
  logic [15:0] disp;
  logic [31:0] index_val;
  logic [4:0]  imm_nb;
  logic [7:0]  str_cnt;
  logic        le_mode;
  logic        busy, done;
  logic [1:0]  status;
  logic        mem_req, mem_we, mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack, mem_fault;
  logic [31:0] mem_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr, rf_raddr;
  logic [31:0] rf_wdata, rf_rdata;

  always #5 clk = ~clk;

  regrun_xfer i_regrun_xfer (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .start_reg(start_reg),
    .base_zero(base_zero), .base_val(base_val), .disp(disp), .index_val(index_val),
    .imm_nb(imm_nb), .str_cnt(str_cnt), .le_mode(le_mode), .busy(busy), .done(done),
    .status(status), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_fault(mem_fault),
    .mem_rdata(mem_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata)
  );

  // memory and register file models
  logic [7:0]  mem [256];
  logic [31:0] rf [32];
  int          lat;
  int          wait_cnt;
  logic        fault_en;
  logic [7:0]  fault_at;
  int          ok_acks, mem_writes;
  int          tests, fails;

  function automatic logic [31:0] bw(input logic [7:0] a);
    return {mem[a], mem[8'(a+1)], mem[8'(a+2)], mem[8'(a+3)]};
  endfunction

  assign mem_ack   = mem_req && (wait_cnt == lat);
  assign mem_fault = mem_req && fault_en && (mem_addr[7:0] == fault_at);
  assign mem_rdata = mem_size ? bw(mem_addr[7:0]) : {24'h0, mem[mem_addr[7:0]]};
  assign rf_rdata  = rf[rf_raddr];

  always @(posedge clk) begin
    if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (mem_req && mem_ack && !mem_fault) begin
      ok_acks <= ok_acks + 1;
      if (mem_we) begin
        mem_writes <= mem_writes + 1;
        if (mem_size) begin
          mem[mem_addr[7:0]]        <= mem_wdata[31:24];
          mem[8'(mem_addr[7:0]+1)]  <= mem_wdata[23:16];
          mem[8'(mem_addr[7:0]+2)]  <= mem_wdata[15:8];
          mem[8'(mem_addr[7:0]+3)]  <= mem_wdata[7:0];
        end else begin
          mem[mem_addr[7:0]] <= mem_wdata[7:0];
        end
      end
    end
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic prep();
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 13 + 5);
    for (int i = 0; i < 32; i++) rf[i] = 32'h5A5A0000 | 32'(i);
    lat = 0;
    fault_en = 1'b0;
    fault_at = 8'h00;
    le_mode = 1'b0;
    base_zero = 1'b0;
    base_val = 32'h0;
    disp = 16'h0;
    index_val = 32'h0;
    imm_nb = 5'd0;
    str_cnt = 8'd0;
  endtask

  // launches the operation set up by the caller and waits for done
  task automatic run(input logic [2:0] code, input bit poke);
    int n;
    @(negedge clk);
    ok_acks = 0;
    mem_writes = 0;
    op = code;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R11 busy after start", {31'h0, busy}, 32'h1);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 1) begin
        start = 1'b1;
        op = 3'd1;
      end else begin
        start = 1'b0;
      end
    end
    if (n >= 2000) check("R11 run timeout", 32'h0, 32'h1);
    start = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 reset busy", {31'h0, busy}, 32'h0);
    check("R11 reset done", {31'h0, done}, 32'h0);
    check("R11 reset req", {31'h0, mem_req}, 32'h0);
    check("R11 reset rf_we", {31'h0, rf_we}, 32'h0);
  endtask

  task automatic t_ldm();
    prep();
    start_reg = 5'd28; base_val = 32'h90; disp = 16'hFFF0;
    run(3'd0, 1'b0);
    check("R1 ldm status", {30'h0, status}, 32'd0);
    for (int k = 0; k < 4; k++) check("R1 ldm reg", rf[28+k], bw(8'(8'h80 + 4*k)));
    check("R1 ldm other reg", rf[27], 32'h5A5A001B);
    check("R1 ldm accesses", 32'(ok_acks), 32'd4);
    @(negedge clk);
    check("R11 idle after done", {31'h0, busy}, 32'h0);
  endtask

  task automatic t_ldm_wait();
    prep();
    lat = 2; start_reg = 5'd30; base_zero = 1'b1; base_val = 32'hDEAD; disp = 16'h0040;
    run(3'd0, 1'b1);
    check("R1 base zero reg30", rf[30], bw(8'h40));
    check("R1 base zero reg31", rf[31], bw(8'h44));
    check("R11 start while busy ignored", 32'(mem_writes), 32'd0);
  endtask

  task automatic t_stm();
    prep();
    rf[29] = 32'h01020304; rf[30] = 32'hA0B0C0D0; rf[31] = 32'hCAFEF00D;
    start_reg = 5'd29; base_val = 32'h08; disp = 16'h0004;
    run(3'd1, 1'b0);
    check("R2 stm status", {30'h0, status}, 32'd0);
    check("R2 stm word0", bw(8'h0C), 32'h01020304);
    check("R2 stm word1", bw(8'h10), 32'hA0B0C0D0);
    check("R2 stm word2", bw(8'h14), 32'hCAFEF00D);
    check("R2 stm beyond", {24'h0, mem[8'h18]}, 32'(8'(8'h18 * 13 + 5)));
  endtask

  task automatic t_align();
    prep();
    start_reg = 5'd20; base_val = 32'h50; disp = 16'h0002;
    run(3'd0, 1'b0);
    check("R3 misaligned status", {30'h0, status}, 32'd1);
    check("R3 misaligned no access", 32'(ok_acks), 32'd0);
    check("R3 misaligned reg kept", rf[20], 32'h5A5A0014);
    prep();
    le_mode = 1'b1; start_reg = 5'd20; base_val = 32'h50;
    run(3'd1, 1'b0);
    check("R3 le status", {30'h0, status}, 32'd1);
    check("R3 le no access", 32'(ok_acks), 32'd0);
  endtask

  task automatic t_str_le();
    prep();
    le_mode = 1'b1; start_reg = 5'd4; base_val = 32'h20; imm_nb = 5'd3;
    run(3'd2, 1'b0);
    check("R4 string le status", {30'h0, status}, 32'd1);
    check("R4 string le no access", 32'(ok_acks), 32'd0);
    check("R4 string le reg kept", rf[4], 32'h5A5A0004);
  endtask

  task automatic t_lsi_wrap();
    prep();
    start_reg = 5'd30; base_val = 32'h20; disp = 16'h0077; imm_nb = 5'd0;
    run(3'd2, 1'b0);
    check("R5 full count accesses", 32'(ok_acks), 32'd32);
    for (int k = 0; k < 8; k++)
      check("R7 wrap reg", rf[5'(30 + k)], bw(8'(8'h20 + 4*k)));
    check("R5 untouched reg6", rf[6], 32'h5A5A0006);
  endtask

  task automatic t_lsx_partial();
    prep();
    rf[0] = 32'hFFFFFFFF;
    start_reg = 5'd31; base_val = 32'h10; index_val = 32'h05; str_cnt = 8'd5;
    run(3'd4, 1'b0);
    check("R6 indexed reg31", rf[31], bw(8'h15));
    check("R8 partial reg0 cleared", rf[0], {mem[8'h19], 24'h0});
    check("R8 reg1 untouched", rf[1], 32'h5A5A0001);
    check("R6 indexed accesses", 32'(ok_acks), 32'd5);
  endtask

  task automatic t_lsx_zero();
    prep();
    start_reg = 5'd9; base_val = 32'h10; str_cnt = 8'd0;
    run(3'd4, 1'b0);
    check("R6 zero count status", {30'h0, status}, 32'd0);
    check("R6 zero count no access", 32'(ok_acks), 32'd0);
    check("R6 zero count reg kept", rf[9], 32'h5A5A0009);
  endtask

  task automatic t_stsx();
    prep();
    rf[3] = 32'hA1B2C3D4; rf[4] = 32'h11223344;
    start_reg = 5'd3; base_zero = 1'b1; base_val = 32'hFF; index_val = 32'h30; str_cnt = 8'd6;
    run(3'd5, 1'b0);
    check("R9 store bytes 0..3", bw(8'h30), 32'hA1B2C3D4);
    check("R9 store byte4", {24'h0, mem[8'h34]}, 32'h11);
    check("R9 store byte5", {24'h0, mem[8'h35]}, 32'h22);
    check("R9 store beyond count", {24'h0, mem[8'h36]}, 32'(8'(8'h36 * 13 + 5)));
  endtask

  task automatic t_ssi_wrap();
    prep();
    rf[31] = 32'h8899AABB; rf[0] = 32'hE1E2E3E4;
    start_reg = 5'd31; base_val = 32'hF0; disp = 16'h0100; imm_nb = 5'd5;
    run(3'd3, 1'b0);
    check("R9 imm store word", bw(8'hF0), 32'h8899AABB);
    check("R7 imm store wrapped byte", {24'h0, mem[8'hF4]}, 32'hE1);
    check("R5 imm store count", 32'(mem_writes), 32'd5);
  endtask

  task automatic t_fault();
    prep();
    fault_en = 1'b1; fault_at = 8'h86;
    start_reg = 5'd5; base_val = 32'h80; imm_nb = 5'd10;
    run(3'd2, 1'b0);
    check("R10 string fault status", {30'h0, status}, 32'd2);
    check("R10 string reg5 kept", rf[5], bw(8'h80));
    check("R10 string reg6 partial", rf[6], {mem[8'h84], mem[8'h85], 16'h0});
    check("R10 string reg7 untouched", rf[7], 32'h5A5A0007);
    check("R10 string good accesses", 32'(ok_acks), 32'd6);
    prep();
    lat = 1; fault_en = 1'b1; fault_at = 8'hA8;
    start_reg = 5'd24; base_val = 32'hA0;
    run(3'd0, 1'b0);
    check("R10 word fault status", {30'h0, status}, 32'd2);
    check("R10 word reg25 kept", rf[25], bw(8'hA4));
    check("R10 word reg26 untouched", rf[26], 32'h5A5A001A);
    check("R10 word good accesses", 32'(ok_acks), 32'd2);
  endtask

  initial begin
    tests = 0; fails = 0; wait_cnt = 0; ok_acks = 0; mem_writes = 0;
    start = 1'b0; op = 3'd0; start_reg = 5'd0;
    prep();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ldm();
    t_ldm_wait();
    t_stm();
    t_align();
    t_str_le();
    t_lsi_wrap();
    t_lsx_partial();
    t_lsx_zero();
    t_stsx();
    t_ssi_wrap();
    t_fault();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++;
    fails++;
    $display("FAIL R11 watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule